// File: doc/BRIEF.md
# Serial Register Access Port

This block is a four-wire serial slave that lets an external host read and write a small byte-wide register file inside the chip. The host lowers an active-low select and clocks bits in on the rising edges of its serial clock. Every transaction starts with a 16-bit command: a direction bit, a two-bit length code and a 13-bit starting address. Data bytes follow the command. The length code asks for one, two or three bytes, or for an open-ended stream that runs until the select is released. During reads the block drives the serial output together with an output-enable. At all other times the enable is low.

The serial pins are synchronized into the system clock domain, and serial-clock edges are detected there. The host may release the select between whole bytes of a fixed-length transaction and continue later. Releasing the select in the middle of a byte abandons the transaction, and no register changes. Bit 0 of register 0 selects the bit order. The address moves down after each byte in MSB-first order and up in LSB-first order. The select may also be held low for good: fixed-length transactions then follow one another directly.

Top module: `serial_reg_port`

## Requirements
- R1: While the select is low, one bit of serial input is taken on each rising edge of the serial clock. While the select is high, serial-clock edges are ignored.
- R2: The first 16 bits of a transaction form the command. Bit 15 gives the direction (1 = read), bits 14:13 give the length (00 = one byte, 01 = two, 10 = three) and bits 12:0 give the start address. In MSB-first order, command bit 15 is sent first.
- R3: Length code 11 starts a stream that transfers bytes until the select rises at a byte boundary. The next transaction then starts with a new command.
- R4: A written byte reaches the register only after its eighth bit. If the select rises while a byte is incomplete, no register changes and the next bits are taken as a new command.
- R5: In a fixed-length transaction the select may rise and fall again between complete bytes (command bytes included). The transaction then continues where it stopped.
- R6: After reset, bit order is MSB-first. When bit 0 of register 0 is 1, the following transactions send the command and the data least significant bit first.
- R7: After each data byte the address decreases by one in MSB-first order and increases by one in LSB-first order. Fixed-length and streaming transactions both follow this rule.
- R8: The output-enable is high only during the data phase of a read while the select is low. The serial output is 0 whenever the enable is low.
- R9: With the select held low, a new command begins at the first bit after a fixed-length transaction finishes.
- R10: After reset every register reads 0 and the output-enable is low.
- R11: The register index is the low log2(REG_DEPTH) bits of the address. Higher address bits alias.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low select |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output-enable for sdo |

## Verification
A serial-clock rising edge reaches the controller state three system clocks after it occurs on the pin, and the read bit and its enable follow one clock later. A fall of the select turns the enable on three clocks later, and a rise turns it off after the same delay. The bench holds each serial-clock level for six system clocks and samples sdo and sdo_oe just before it raises the clock, so every result has settled by then. It waits eight clocks after lowering the select and ten after raising it. Its every-clock check on the quiet output starts only after the select has been high for four clocks.

// File: rtl/serial_reg_pkg.sv
package serial_reg_pkg;
    localparam int CMD_W  = 16;
    localparam int ADDR_W = 13;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_CMD_HI = 2'd0,
        PH_CMD_LO = 2'd1,
        PH_DATA   = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        logic [2:0]          bidx;
        logic [CMD_W-1:0]    shr;
        logic                rd;
        logic                stream;
        logic [1:0]          left;
        logic [ADDR_W-1:0]   addr;
        logic                lsb;
        logic                sdo;
        logic                oe;
    } ctl_s;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[0] <= RST_VAL;
        else        pipe_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[s] <= RST_VAL;
            else        pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/srp_regs.sv
module srp_regs #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata,
    output logic             cfg_lsb
);
    logic [7:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             mem_q[g] <= '0;
            else if (we && waddr == IDX_W'(g))      mem_q[g] <= wdata;
        end
    end

    assign rdata   = mem_q[raddr];
    assign cfg_lsb = mem_q[0][0];
endmodule

// File: rtl/srp_ctl.sv
module srp_ctl
    import serial_reg_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise,
    input  logic             cs_act,
    input  logic             cs_rise,
    input  logic             sdi_s,
    input  logic             cfg_lsb,
    input  logic [7:0]       rd_data,
    output logic             we,
    output logic [IDX_W-1:0] waddr,
    output logic [7:0]       wdata,
    output logic [IDX_W-1:0] raddr,
    output logic             sdo,
    output logic             sdo_oe,
    output phase_e           phase,
    output logic [2:0]       bit_idx
);
    ctl_s q, d;

    logic [CMD_W-1:0]  cmd_next;
    logic [7:0]        byte_next;
    logic [ADDR_W-1:0] addr_step;
    logic [2:0]        sel;

    always_comb begin
        d        = q;
        we       = 1'b0;
        wdata    = '0;
        cmd_next  = cfg_lsb ? {sdi_s, q.shr[CMD_W-1:1]} : {q.shr[CMD_W-2:0], sdi_s};
        byte_next = q.lsb ? {sdi_s, q.shr[7:1]} : {q.shr[6:0], sdi_s};
        addr_step = q.lsb ? q.addr + 13'd1 : q.addr - 13'd1;

        if (cs_rise) begin
            // partial byte or end of stream: back to command
            if (q.bidx != 3'd0 || (q.ph == PH_DATA && q.stream)) begin
                d.ph     = PH_CMD_HI;
                d.bidx   = '0;
                d.rd     = 1'b0;
                d.stream = 1'b0;
            end
        end else if (cs_act && sclk_rise) begin
            d.bidx = q.bidx + 3'd1;
            unique case (q.ph)
                PH_CMD_HI: begin
                    d.shr = cmd_next;
                    if (q.bidx == 3'd7) d.ph = PH_CMD_LO;
                end
                PH_CMD_LO: begin
                    d.shr = cmd_next;
                    if (q.bidx == 3'd7) begin
                        d.ph     = PH_DATA;
                        d.rd     = cmd_next[15];
                        d.stream = &cmd_next[14:13];
                        d.left   = cmd_next[14:13];
                        d.addr   = cmd_next[ADDR_W-1:0];
                        d.lsb    = cfg_lsb;
                    end
                end
                PH_DATA: begin
                    d.shr[7:0] = byte_next;
                    if (q.bidx == 3'd7) begin
                        if (!q.rd) begin
                            we    = 1'b1;
                            wdata = byte_next;
                        end
                        d.addr = addr_step;
                        if (!q.stream) begin
                            if (q.left == 2'd0) begin
                                d.ph = PH_CMD_HI;
                                d.rd = 1'b0;
                            end else begin
                                d.left = q.left - 2'd1;
                            end
                        end
                    end
                end
                default: d.ph = PH_CMD_HI;
            endcase
        end

        sel   = q.lsb ? q.bidx : 3'd7 - q.bidx;
        d.oe  = cs_act && (q.ph == PH_DATA) && q.rd;
        d.sdo = d.oe ? rd_data[sel] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= PH_CMD_HI;
        end else begin
            q <= d;
        end
    end

    assign waddr   = q.addr[IDX_W-1:0];
    assign raddr   = q.addr[IDX_W-1:0];
    assign sdo     = q.sdo;
    assign sdo_oe  = q.oe;
    assign phase   = q.ph;
    assign bit_idx = q.bidx;
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import serial_reg_pkg::*;
#(
    parameter int REG_DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdi,
    input  logic cs_n,
    output logic sdo,
    output logic sdo_oe
);
    localparam int IDX_W = $clog2(REG_DEPTH);

    logic [2:0]       pins_s;
    logic             sclk_s, sdi_s, cs_s;
    logic             sclk_prev_q, cs_prev_q;
    logic             sclk_rise, cs_rise, cs_act;
    logic             wr_en, cfg_lsb;
    logic [IDX_W-1:0] waddr, raddr;
    logic [7:0]       wdata, rdata;
    phase_e           phase;
    logic [2:0]       bit_idx;

    srp_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sdi, sclk}), .q(pins_s)
    );
    assign {cs_s, sdi_s, sclk_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            cs_prev_q   <= 1'b1;
        end else begin
            sclk_prev_q <= sclk_s;
            cs_prev_q   <= cs_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_prev_q;
    assign cs_rise   = cs_s & ~cs_prev_q;
    assign cs_act    = ~cs_s;

    srp_regs #(.DEPTH(REG_DEPTH), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata), .cfg_lsb(cfg_lsb)
    );

    srp_ctl #(.IDX_W(IDX_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .cs_act(cs_act),
        .cs_rise(cs_rise), .sdi_s(sdi_s), .cfg_lsb(cfg_lsb), .rd_data(rdata),
        .we(wr_en), .waddr(waddr), .wdata(wdata), .raddr(raddr),
        .sdo(sdo), .sdo_oe(sdo_oe), .phase(phase), .bit_idx(bit_idx)
    );
endmodule

// File: rtl/srp_checker.sv
module srp_checker
    import serial_reg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sdo_oe,
    input logic       wr_en,
    input logic       sclk_rise,
    input logic       cs_act,
    input logic       cs_rise,
    input logic [2:0] bit_idx,
    input phase_e     phase
);
    assert_oe_needs_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n, 3) |-> !sdo_oe);

    assert_no_oe_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !sdo_oe);

    assert_commit_full_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (sclk_rise && cs_act && bit_idx == 3'd7 && phase == PH_DATA));

    assert_abort_to_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && bit_idx != 3'd0) |=> (bit_idx == 3'd0 && phase == PH_CMD_HI));

    assert_idle_when_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && !cs_rise) |=> ($stable(bit_idx) && $stable(phase)));

    assert_edge_advances_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && sclk_rise) |=> bit_idx == $past(bit_idx) + 3'd1);
endmodule

bind serial_reg_port srp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_oe(sdo_oe), .wr_en(wr_en),
    .sclk_rise(sclk_rise), .cs_act(cs_act), .cs_rise(cs_rise),
    .bit_idx(bit_idx), .phase(phase)
);

// File: tb/sim_serial_reg_port.sv
`timescale 1ns/1ps
module sim_serial_reg_port;
    localparam int DEPTH = 16;
    localparam int HALF  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic cs_n = 1'b1;
    logic sdo, sdo_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int cs_hi_cnt = 0;

    logic [7:0] model [DEPTH];
    bit         lsb_m = 1'b0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    always #2 clk = ~clk;

    serial_reg_port #(.REG_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every-clock model of the quiet output (R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cs_n) cs_hi_cnt++;
            else      cs_hi_cnt = 0;
            if (cs_hi_cnt >= 4) check(!sdo_oe && !sdo, "R8 quiet while deselected",
                                      {sdo_oe, sdo}, 0);
        end
    end

    task automatic clock_bit(input logic b, output logic so, output logic oe);
        @(negedge clk);
        sdi = b;
        repeat (HALF) @(negedge clk);
        so = sdo;
        oe = sdo_oe;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_word(input int n, input logic [15:0] val, input bit lsb,
                             output logic [15:0] rx, output int oe_cnt);
        logic so, oe;
        rx = '0;
        oe_cnt = 0;
        for (int i = 0; i < n; i++) begin
            int idx;
            idx = lsb ? i : n - 1 - i;
            clock_bit(val[idx], so, oe);
            rx[idx] = so;
            oe_cnt += int'(oe);
        end
    endtask

    task automatic sel_low();
        if (cs_n) begin
            cs_n = 1'b0;
            repeat (8) @(negedge clk);
        end
    endtask

    task automatic sel_high();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic do_txn(input bit rd, input logic [1:0] lenf, input logic [12:0] addr,
                          input int nbytes, input bit pause, input bit keep_cs,
                          input string req);
        logic [15:0] rx;
        int oec;
        int a;
        bit touched0 = 1'b0;
        sel_low();
        send_word(16, {rd, lenf, addr}, lsb_m, rx, oec);
        check(oec == 0, {req, " R8 no drive during command"}, oec, 0);
        a = int'(addr) % DEPTH;
        for (int i = 0; i < nbytes; i++) begin
            if (pause) begin
                cs_n = 1'b1;
                repeat (10) @(negedge clk);
                cs_n = 1'b0;
                repeat (8) @(negedge clk);
            end
            send_word(8, rd ? 16'h0 : {8'h0, wbuf[i]}, lsb_m, rx, oec);
            if (rd) begin
                rbuf[i] = rx[7:0];
                check(oec == 8, {req, " R8 drive during read data"}, oec, 8);
                check(rx[7:0] == model[a], req, rx[7:0], model[a]);
            end else begin
                check(oec == 0, {req, " R8 no drive during write"}, oec, 0);
                model[a] = wbuf[i];
                if (a == 0) touched0 = 1'b1;
            end
            a = lsb_m ? (a + 1) % DEPTH : (a + DEPTH - 1) % DEPTH;
        end
        if (!keep_cs) sel_high();
        if (touched0) lsb_m = model[0][0];
    endtask

    task automatic abort_after(input logic [15:0] val, input int nbits);
        logic [15:0] rx;
        int oec;
        sel_low();
        send_word(nbits, val, 1'b0, rx, oec);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [15:0] rx;
        int oec;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10: reset state
        check(sdo_oe == 1'b0, "R10 oe low after reset", sdo_oe, 0);
        do_txn(1'b1, 2'b00, 13'd5, 1, 1'b0, 1'b0, "R10 reset value");

        // R1 R2: single byte write and read back, MSB-first default (R6)
        wbuf[0] = 8'hA5;
        do_txn(1'b0, 2'b00, 13'd3, 1, 1'b0, 1'b0, "R2 write");
        do_txn(1'b1, 2'b00, 13'd3, 1, 1'b0, 1'b0, "R2 R6 read back msb-first");

        // R7: three bytes, address decrements
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_txn(1'b0, 2'b10, 13'd10, 3, 1'b0, 1'b0, "R7 write x3");
        do_txn(1'b1, 2'b10, 13'd10, 3, 1'b0, 1'b0, "R7 read x3");
        do_txn(1'b1, 2'b00, 13'd8, 1, 1'b0, 1'b0, "R7 decremented address");

        // R5: pauses between bytes
        wbuf[0] = 8'h5C; wbuf[1] = 8'hC3;
        do_txn(1'b0, 2'b01, 13'd6, 2, 1'b1, 1'b0, "R5 paused write");
        do_txn(1'b1, 2'b01, 13'd6, 2, 1'b1, 1'b0, "R5 paused read");

        // R4: abort mid data byte, then mid command
        abort_after({1'b0, 2'b00, 13'd3}, 16);
        sel_low();
        send_word(4, 16'h000F, 1'b0, rx, oec);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        do_txn(1'b1, 2'b00, 13'd3, 1, 1'b0, 1'b0, "R4 partial byte discarded");
        abort_after({1'b0, 2'b00, 13'd3}, 5);
        do_txn(1'b1, 2'b00, 13'd3, 1, 1'b0, 1'b0, "R4 new command after abort");

        // R3: streaming write and read
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04; wbuf[4] = 8'h05;
        do_txn(1'b0, 2'b11, 13'd15, 5, 1'b0, 1'b0, "R3 stream write");
        do_txn(1'b1, 2'b11, 13'd15, 5, 1'b0, 1'b0, "R3 stream read");
        do_txn(1'b1, 2'b00, 13'd12, 1, 1'b0, 1'b0, "R3 stream ended on select");

        // R9: select held low across two transactions
        wbuf[0] = 8'h7E;
        do_txn(1'b0, 2'b00, 13'd7, 1, 1'b0, 1'b1, "R9 write held select");
        do_txn(1'b1, 2'b00, 13'd7, 1, 1'b0, 1'b0, "R9 read held select");

        // R11: high address bits alias
        wbuf[0] = 8'h96;
        do_txn(1'b0, 2'b00, 13'h0104, 1, 1'b0, 1'b0, "R11 aliased write");
        do_txn(1'b1, 2'b00, 13'd4, 1, 1'b0, 1'b0, "R11 aliased read");

        // R6 R7: switch to LSB-first, address increments
        wbuf[0] = 8'h01;
        do_txn(1'b0, 2'b00, 13'd0, 1, 1'b0, 1'b0, "R6 set lsb-first");
        check(lsb_m == 1'b1, "R6 model switched", lsb_m, 1);
        wbuf[0] = 8'h3C; wbuf[1] = 8'hE1;
        do_txn(1'b0, 2'b01, 13'd1, 2, 1'b0, 1'b0, "R6 R7 lsb write");
        do_txn(1'b1, 2'b01, 13'd1, 2, 1'b0, 1'b0, "R6 R7 lsb read");
        do_txn(1'b1, 2'b00, 13'd2, 1, 1'b0, 1'b0, "R7 incremented address");
        do_txn(1'b1, 2'b11, 13'd10, 3, 1'b0, 1'b0, "R3 R6 lsb stream read");

        // R6: back to MSB-first
        wbuf[0] = 8'h00;
        do_txn(1'b0, 2'b00, 13'd0, 1, 1'b0, 1'b0, "R6 clear lsb-first");
        check(lsb_m == 1'b0, "R6 model restored", lsb_m, 0);
        do_txn(1'b1, 2'b00, 13'd3, 1, 1'b0, 1'b0, "R6 msb read again");

        repeat (10) @(negedge clk);
        finish_up();
    end
endmodule